// File: doc/BRIEF.md
# DC Offset Correction Filter

This block removes the slowly varying DC component from a signed 12-bit sample stream, one sample per clock. It keeps a running DC estimate in a wide fixed-point accumulator. The accumulator acts as a first-order leaky integrator, so the corrected path behaves as a high-pass filter. A 4-bit code sets the integrator's shift. The corner frequency is the sample rate divided by 2π·2^(code+14). That is roughly 1.2 kHz at code 0 and 0.15 Hz at code 13 for a 125 MHz sample rate.

Three control bits are provided:

- One bit turns the estimation on, for example when the estimate only feeds monitoring logic downstream.
- One bit subtracts the estimate from the data path.
- One bit freezes the estimate at its present value.

The 12-bit estimate is visible on a port at all times. The corrected data leaves through a register with a matching valid strobe. The data is clamped to the signed 12-bit range.

Top module: `dc_offset_corrector`

## Requirements
- R1: While `rst_n` is low and after its release, `dc_est` is 0, `out_valid` is 0 and `out_data` is 0, until the first valid sample is taken.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` belongs to the sample presented one clock earlier.
- R3: When `apply_en` is 0, `out_data` equals the input sample unchanged.
- R4: When `apply_en` is 1, `out_data` is the input sample minus the `dc_est` value that was present in the same cycle as that sample. The estimate is the value before any update caused by that sample.
- R5: The subtraction of R4 saturates. Results above 2047 give 2047, and results below -2048 give -2048.
- R6: The estimate update rule is described in the list after the requirements.
- R7: The code values 14 and 15 of `k_sel` produce exactly the same shift as code 13, which is a shift of 27.
- R8: While `freeze` is 1, `dc_est` does not change. The held value is still applied by R4. After `freeze` returns to 0, updating resumes from the held value.
- R9: A cycle with `in_valid` 0 or `est_en` 0 leaves `dc_est` unchanged.

The update rule of R6 works as follows:

- An update happens on a clock where `in_valid` is 1, `est_en` is 1 and `freeze` is 0.
- The accumulator A is a signed value with 27 fractional bits, and it starts at 0.
- Each update performs A ← A + floor((x·2^27 − A) / 2^(k+14)).
- Here x is the input sample and k is the value of `k_sel`, limited to at most 13.
- `dc_est` is floor(A / 2^27), a signed 12-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| k_sel | input | 4 | Bandwidth shift code; codes above 13 act as 13 |
| est_en | input | 1 | Enables estimate updates |
| apply_en | input | 1 | Subtracts the estimate from the output data |
| freeze | input | 1 | Holds the estimate |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Corrected (or passed-through) signed sample |
| dc_est | output | 12 | Current signed DC estimate |

## Verification
Two situations are hard to reach. The first is output saturation, which needs an estimate of a few hundred LSB. The bench builds it by running about two thousand full-scale negative samples at the fastest setting. It then freezes the estimate and applies a positive full-scale sample, and repeats the process in the other direction to reach the negative clamp.

The second is telling code 15 apart from a deeper shift. At that setting the estimate only moves by its first LSB after about 65,000 full-scale samples. The bench runs its reference model sample by sample until the model predicts that step, and checks `dc_est` at that sample.

// File: rtl/dc_offset_corrector.sv
module dc_offset_corrector #(
  parameter int DW   = 12,
  parameter int KW   = 4,
  parameter int KMAX = 13,
  parameter int SB   = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [KW-1:0] k_sel,
  input  logic          est_en,
  input  logic          apply_en,
  input  logic          freeze,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] dc_est
);
  localparam int FRAC = SB + KMAX;
  localparam int AW   = DW + FRAC + 1;
  localparam int SW   = $clog2(FRAC + 1);

  logic signed [AW-1:0] acc, xs, err, acc_nxt;
  logic [KW-1:0]        k_eff;
  logic [SW-1:0]        shamt;
  logic signed [DW:0]   diff;
  logic [DW-1:0]        corr;

  assign k_eff   = (k_sel > KW'(KMAX)) ? KW'(KMAX) : k_sel;
  assign shamt   = SW'(k_eff) + SW'(SB);
  assign xs      = {in_data[DW-1], in_data, {FRAC{1'b0}}};
  assign err     = xs - acc;
  assign acc_nxt = acc + (err >>> shamt);
  assign dc_est  = acc[AW-2 -: DW];

  assign diff = {in_data[DW-1], in_data} - {dc_est[DW-1], dc_est};
  assign corr = (diff[DW] == diff[DW-1]) ? diff[DW-1:0]
              : {diff[DW], {(DW-1){~diff[DW]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= apply_en ? corr : in_data;
        if (est_en && !freeze) acc <= acc_nxt;
      end
    end
  end
endmodule

// File: rtl/dc_offset_corrector_chk.sv
module dc_offset_corrector_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          est_en,
  input logic          apply_en,
  input logic          freeze,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [DW-1:0] dc_est
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !apply_en) |=> (out_data == $past(in_data)));
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(dc_est));
  a_r9_no_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !est_en) |=> $stable(dc_est));
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (dc_est == '0 && !out_valid && out_data == '0));
endmodule

bind dc_offset_corrector dc_offset_corrector_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .est_en(est_en), .apply_en(apply_en), .freeze(freeze),
  .out_valid(out_valid), .out_data(out_data), .dc_est(dc_est)
);

// File: tb/dc_offset_corrector_tb_top.sv
module dc_offset_corrector_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, est_en = 1'b0, apply_en = 1'b0, freeze = 1'b0;
  logic [11:0] in_data = '0;
  logic [3:0]  k_sel = '0;
  logic        out_valid;
  logic [11:0] out_data, dc_est;
  int total = 0, bad = 0;
  longint macc = 0;

  always #5 clk = ~clk;

  dc_offset_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .k_sel(k_sel), .est_en(est_en), .apply_en(apply_en), .freeze(freeze),
    .out_valid(out_valid), .out_data(out_data), .dc_est(dc_est)
  );

  function automatic longint mdc();
    return macc >>> 27;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    macc = 0;
    chk(dc_est == 0 && out_valid == 0 && out_data == 0, "R1", longint'(dc_est), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(dc_est == 0 && out_valid == 0 && out_data == 0, "R1", longint'(out_data), 0);
  endtask

  task automatic step(input bit v, input longint x, input string rq);
    longint exp_o, d, kk;
    d = mdc();
    in_valid = v; in_data = 12'(x);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (apply_en) begin
      exp_o = x - d;
      if (exp_o > 2047) exp_o = 2047;
      if (exp_o < -2048) exp_o = -2048;
    end else exp_o = x;
    if (v && est_en && !freeze) begin
      kk = (k_sel > 13) ? 13 : longint'(k_sel);
      macc = macc + (((x <<< 27) - macc) >>> (kk + 14));
    end
    chk(out_valid == v, "R2", longint'(out_valid), longint'(v));
    if (v) chk(longint'($signed(out_data)) == exp_o, rq, longint'($signed(out_data)), exp_o);
    chk(longint'($signed(dc_est)) == mdc(), "R6", longint'($signed(dc_est)), mdc());
  endtask

  task automatic t_pass();
    est_en = 0; apply_en = 0; freeze = 0; k_sel = 0;
    step(1, 2047, "R3"); step(1, -2048, "R3"); step(1, 5, "R3");
    chk(dc_est == 0, "R9", longint'(dc_est), 0);
  endtask

  task automatic t_track();
    est_en = 1; apply_en = 1; k_sel = 0;
    for (int i = 0; i < 40; i++) step(1, 2047, "R4");
    chk(mdc() > 0, "R6", mdc(), 1);
  endtask

  task automatic t_gap();
    logic [11:0] held;
    held = dc_est;
    for (int i = 0; i < 4; i++) step(0, 2047, "R2");
    chk(dc_est == held, "R9", longint'(dc_est), longint'(held));
    est_en = 0;
    step(1, -2048, "R4");
    chk(dc_est == held, "R9", longint'(dc_est), longint'(held));
    est_en = 1;
  endtask

  task automatic t_freeze();
    logic [11:0] held;
    held = dc_est; freeze = 1;
    for (int i = 0; i < 20; i++) step(1, -2048, "R8");
    chk(dc_est == held, "R8", longint'(dc_est), longint'(held));
    freeze = 0;
    for (int i = 0; i < 20; i++) step(1, -2048, "R8");
    chk(dc_est != held, "R8", longint'(dc_est), longint'(held));
  endtask

  task automatic t_sat();
    apply_en = 0; k_sel = 0;
    for (int i = 0; i < 2000; i++) step(1, -2048, "R3");
    chk(mdc() < -100, "R6", mdc(), -100);
    freeze = 1; apply_en = 1;
    step(1, 2047, "R5");
    chk($signed(out_data) == 2047, "R5", longint'($signed(out_data)), 2047);
    freeze = 0; apply_en = 0;
    for (int i = 0; i < 6000; i++) step(1, 2047, "R3");
    chk(mdc() > 100, "R6", mdc(), 100);
    freeze = 1; apply_en = 1;
    step(1, -2048, "R5");
    chk($signed(out_data) == -2048, "R5", longint'($signed(out_data)), -2048);
    freeze = 0;
  endtask

  task automatic t_kclamp();
    int n;
    do_reset();
    est_en = 1; apply_en = 0; freeze = 0; k_sel = 4'd15;
    n = 0;
    while (mdc() == 0 && n < 70000) begin
      in_valid = 1; in_data = 12'd2047;
      @(posedge clk); #1;
      macc = macc + (((longint'(2047) <<< 27) - macc) >>> 27);
      n++;
      if (mdc() == 0 && dc_est != 0) chk(0, "R7", longint'(dc_est), 0);
    end
    in_valid = 0;
    chk(mdc() == 1, "R7", mdc(), 1);
    chk(dc_est == 1, "R7", longint'(dc_est), 1);
    k_sel = 4'd14;
    step(1, 2047, "R7");
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_pass();
    t_track();
    t_gap();
    t_freeze();
    t_sat();
    t_kclamp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule